// File: doc/BRIEF.md
# Per-Bit Configurable GPIO Port Controller

This block runs the digital side of one general-purpose I/O port. Each bit of the port has its own output type, picked by the two configuration registers. Each register holds one bit for each pin. From the port latch and the chosen type, the block works out three enables for each pin's pad: the strong pull-down, the strong pull-up and the weak pull-up. Every pad input passes through a two-flop synchronizer. For pins set to the quasi-bidirectional type, the input then also passes through a glitch filter. The result can be read back through the register interface.

There are four output types:
- Quasi-bidirectional: weak high and strong low. When the latch goes from 0 to 1, a short strong pull-up boost speeds the rising edge.
- Push-pull: strong high and strong low.
- Open-drain: strong low only.
- Input-only: no driver at all.

One pin is fixed as input-only. Two pins accept only the open-drain or input-only type. A write that asks for a type those pins cannot take is mapped to the nearest type they allow.

Each pin has two small state machines. The drive machine has two states: `DRV_IDLE` (no boost) and `DRV_BOOST` (strong pull-up on). Its transitions are:
- `DRV_IDLE`→`DRV_BOOST` when the latch is written from 0 to 1 while the pin is quasi-bidirectional.
- `DRV_BOOST`→`DRV_IDLE` when the boost count expires, when the latch is cleared, or when the pin leaves the quasi-bidirectional type.

The filter machine has two states: `FLT_STABLE` (the accepted level matches the synchronized input) and `FLT_PEND` (a different level is being timed). Its transitions are:
- `FLT_STABLE`→`FLT_PEND` on the first sample that differs from the accepted level.
- `FLT_PEND`→`FLT_STABLE` either when the input returns to the accepted level (the candidate is dropped) or when the new level has been held long enough (it is accepted).

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every pin is input-only: the cfg1 register (address 1) reads 0xFF, the cfg2 register (address 2) reads 0x00, the latch (read at address 3) reads 0xFF, and all pad enables are 0.
- R2: The type encoding {cfg1 bit, cfg2 bit} is 00 quasi-bidirectional, 01 push-pull, 10 input-only and 11 open-drain. A write to address 0 loads the latch. Writes to addresses 1 and 2 load cfg1 and cfg2. Address 3 returns the latch and ignores writes. Reads of addresses 1 and 2 return the effective type bits.
- R3: A quasi-bidirectional pin enables the weak pull-up when its latch bit is 1 and the strong pull-down when its latch bit is 0.
- R4: A push-pull pin enables the strong pull-up when its latch bit is 1 and the strong pull-down when it is 0.
- R5: An open-drain pin never enables a pull-up. It enables the strong pull-down only when its latch bit is 0.
- R6: An input-only pin enables no driver, whatever its latch bit.
- R7: On a quasi-bidirectional pin, a write that takes the latch bit from 0 to 1 enables the strong pull-up for exactly 2 cycles after that write's clock edge. No other type ever gets this boost.
- R8: Pin 5 is always input-only. It reads back as 10 and drives nothing, whatever is written to its configuration bits.
- R9: Pins 2 and 3 take only input-only (10) or open-drain (11). Any other requested encoding becomes open-drain, and the readback shows the effective encoding.
- R10: The input of a quasi-bidirectional pin is synchronized and then filtered. A new level appears at address 0 after the 5th clock edge following the pad change, and a pulse that lasts 2 clocks never appears.
- R11: The input of a pin of any other type bypasses the filter. It appears at address 0 after the 2nd clock edge following the pad change.
- R12: On no pin are the strong pull-down and a pull-up enabled at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 pins/latch, 1 cfg1, 2 cfg2, 3 latch readback) |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data for reg_addr |
| pad_in | input | W | Raw pad input levels |
| pad_pd_en | output | W | Strong pull-down enable per pin |
| pad_pu_strong_en | output | W | Strong pull-up enable per pin |
| pad_pu_weak_en | output | W | Weak pull-up enable per pin |
| pin_level | output | W | Conditioned input level per pin |

## Verification
The bench checks the following corners:
- Boost length. A boost that is one cycle too short or too long, or that also fires on an open-drain pin, shows up on the strong pull-up outputs sampled on the three cycles after the latch write.
- Filter boundary. The bench sends a 2-clock glitch, which must be dropped, and a 3-clock pulse, which must pass. An off-by-one in the filter count either lets the glitch through or loses the pulse.
- Filter bypass. Open-drain and input-only pins must follow the pad two edges after a change. A design that filters every pin would show them late.
- Restricted pins. The hardwired pins must read back and drive as their narrowed types under every written pattern. A design that let raw encodings through would drive a pull-up on pin 2, 3 or 5.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        MODE_QUASI     = 2'b00,
        MODE_PUSHPULL  = 2'b01,
        MODE_INPUT     = 2'b10,
        MODE_OPENDRAIN = 2'b11
    } pin_mode_e;

    typedef enum logic {
        DRV_IDLE  = 1'b0,
        DRV_BOOST = 1'b1
    } drv_state_e;

    typedef enum logic {
        FLT_STABLE = 1'b0,
        FLT_PEND   = 1'b1
    } flt_state_e;

    localparam logic [1:0] ADDR_PORT  = 2'd0;
    localparam logic [1:0] ADDR_CFG1  = 2'd1;
    localparam logic [1:0] ADDR_CFG2  = 2'd2;
    localparam logic [1:0] ADDR_LATCH = 2'd3;

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_pkg::*;
#(
    parameter int          W            = 8,
    parameter int          FIXED_IN_BIT = 5,
    parameter logic [W-1:0] OD_ONLY_MASK = 8'h0C
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] cfg1_eff,
    output logic [W-1:0] cfg2_eff,
    output logic [W-1:0] latch_rise
);

    logic [W-1:0] cfg1_raw;
    logic [W-1:0] cfg2_raw;
    logic         wr_latch;

    assign wr_latch = wr_en && (addr == ADDR_PORT);

    // Raw storage; effective type is derived below so cfg1/cfg2 may be
    // written in either order.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q  <= '1;
            cfg1_raw <= '1;
            cfg2_raw <= '0;
        end else if (wr_en) begin
            unique case (addr)
                ADDR_PORT:  latch_q  <= wdata;
                ADDR_CFG1:  cfg1_raw <= wdata;
                ADDR_CFG2:  cfg2_raw <= wdata;
                ADDR_LATCH: ;
            endcase
        end
    end

    // One-cycle flag: latch bit about to go from 0 to 1.
    assign latch_rise = wr_latch ? (wdata & ~latch_q) : '0;

    for (genvar b = 0; b < W; b++) begin : g_map
        if (b == FIXED_IN_BIT) begin : g_fixed
            assign cfg1_eff[b] = 1'b1;
            assign cfg2_eff[b] = 1'b0;
        end else if (OD_ONLY_MASK[b]) begin : g_restricted
            // input-only stays; everything else narrows to open-drain
            assign cfg1_eff[b] = 1'b1;
            assign cfg2_eff[b] = !(cfg1_raw[b] && !cfg2_raw[b]);
        end else begin : g_free
            assign cfg1_eff[b] = cfg1_raw[b];
            assign cfg2_eff[b] = cfg2_raw[b];
        end
    end

endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv
    import gpio_pkg::*;
#(
    parameter int BOOST_LEN = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pin_mode_e mode,
    input  logic      latch,
    input  logic      boost_start,
    output logic      pd_en,
    output logic      pu_strong_en,
    output logic      pu_weak_en
);

    localparam int CW = (BOOST_LEN > 1) ? $clog2(BOOST_LEN) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(BOOST_LEN - 1);

    drv_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DRV_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DRV_IDLE: begin
                if (boost_start && mode == MODE_QUASI) begin
                    state_d = DRV_BOOST;
                    cnt_d   = '0;
                end
            end
            DRV_BOOST: begin
                if (mode != MODE_QUASI || !latch || cnt_q == CNT_LAST) begin
                    state_d = DRV_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        pd_en        = 1'b0;
        pu_strong_en = 1'b0;
        pu_weak_en   = 1'b0;
        unique case (mode)
            MODE_QUASI: begin
                pd_en        = !latch;
                pu_weak_en   = latch;
                pu_strong_en = latch && (state_q == DRV_BOOST);
            end
            MODE_PUSHPULL: begin
                pd_en        = !latch;
                pu_strong_en = latch;
            end
            MODE_OPENDRAIN: pd_en = !latch;
            MODE_INPUT: ;
        endcase
    end

endmodule

// File: rtl/gpio_in_filt.sv
module gpio_in_filt
    import gpio_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter int   FILT_LEN    = 3,
    parameter logic RST_LEVEL   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad,
    output logic sync_q,
    output logic filt_q
);

    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

    logic [SYNC_STAGES-1:0] sync_sh;
    flt_state_e             state_q, state_d;
    logic [CW-1:0]          cnt_q, cnt_d;
    logic                   filt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_sh <= {SYNC_STAGES{RST_LEVEL}};
        else        sync_sh <= {sync_sh[SYNC_STAGES-2:0], pad};
    end

    assign sync_q = sync_sh[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_STABLE;
            cnt_q   <= '0;
            filt_q  <= RST_LEVEL;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            filt_q  <= filt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        filt_d  = filt_q;
        unique case (state_q)
            FLT_STABLE: begin
                if (sync_q != filt_q) begin
                    state_d = FLT_PEND;
                    cnt_d   = CW'(1);
                end
            end
            FLT_PEND: begin
                if (sync_q == filt_q) begin
                    state_d = FLT_STABLE;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = FLT_STABLE;
                    cnt_d   = '0;
                    filt_d  = sync_q;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int           W            = 8,
    parameter int           FIXED_IN_BIT = 5,
    parameter logic [W-1:0] OD_ONLY_MASK = 8'h0C,
    parameter int           SYNC_STAGES  = 2,
    parameter int           FILT_LEN     = 3,
    parameter int           BOOST_LEN    = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_pd_en,
    output logic [W-1:0] pad_pu_strong_en,
    output logic [W-1:0] pad_pu_weak_en,
    output logic [W-1:0] pin_level
);

    logic [W-1:0] latch_q;
    logic [W-1:0] cfg1_eff;
    logic [W-1:0] cfg2_eff;
    logic [W-1:0] latch_rise;
    logic [W-1:0] sync_vec;
    logic [W-1:0] filt_vec;

    gpio_cfg_regs #(
        .W            (W),
        .FIXED_IN_BIT (FIXED_IN_BIT),
        .OD_ONLY_MASK (OD_ONLY_MASK)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .latch_q    (latch_q),
        .cfg1_eff   (cfg1_eff),
        .cfg2_eff   (cfg2_eff),
        .latch_rise (latch_rise)
    );

    for (genvar b = 0; b < W; b++) begin : g_pin
        pin_mode_e mode_b;
        assign mode_b = pin_mode_e'({cfg1_eff[b], cfg2_eff[b]});

        gpio_pin_drv #(
            .BOOST_LEN (BOOST_LEN)
        ) u_drv (
            .clk          (clk),
            .rst_n        (rst_n),
            .mode         (mode_b),
            .latch        (latch_q[b]),
            .boost_start  (latch_rise[b]),
            .pd_en        (pad_pd_en[b]),
            .pu_strong_en (pad_pu_strong_en[b]),
            .pu_weak_en   (pad_pu_weak_en[b])
        );

        gpio_in_filt #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN),
            .RST_LEVEL   (1'b1)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .pad    (pad_in[b]),
            .sync_q (sync_vec[b]),
            .filt_q (filt_vec[b])
        );

        assign pin_level[b] = (mode_b == MODE_QUASI) ? filt_vec[b] : sync_vec[b];
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_PORT:  reg_rdata = pin_level;
            ADDR_CFG1:  reg_rdata = cfg1_eff;
            ADDR_CFG2:  reg_rdata = cfg2_eff;
            ADDR_LATCH: reg_rdata = latch_q;
        endcase
    end

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
    import gpio_pkg::*;
#(
    parameter int           W            = 8,
    parameter int           FIXED_IN_BIT = 5,
    parameter logic [W-1:0] OD_ONLY_MASK = 8'h0C
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] pd,
    input logic [W-1:0] pus,
    input logic [W-1:0] puw,
    input logic [W-1:0] cfg1_eff,
    input logic [W-1:0] cfg2_eff,
    input logic [W-1:0] latch_q,
    input logic [W-1:0] sync_v,
    input logic [W-1:0] filt_v
);

    // R12
    no_drive_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd & (pus | puw)) == '0);

    // R8
    fixed_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd[FIXED_IN_BIT] && !pus[FIXED_IN_BIT] && !puw[FIXED_IN_BIT]
        && {cfg1_eff[FIXED_IN_BIT], cfg2_eff[FIXED_IN_BIT]} == MODE_INPUT);

    // R9
    restricted_no_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pus | puw) & OD_ONLY_MASK) == '0);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] m;
        assign m = {cfg1_eff[i], cfg2_eff[i]};

        // R6
        input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (m == MODE_INPUT) |-> !(pd[i] || pus[i] || puw[i]));

        // R3
        quasi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (m == MODE_QUASI && !latch_q[i]) |-> (pd[i] && !puw[i]));

        // R7 (window sized for the default boost length of 2)
        boost_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (m == MODE_QUASI && $past(m) == MODE_QUASI && $past(m, 2) == MODE_QUASI)
            |-> !(pus[i] && $past(pus[i]) && $past(pus[i], 2)));

        // R10 (window sized for the default filter length of 3)
        filt_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(filt_v[i]) |-> ($past(sync_v[i]) == filt_v[i]
                && $past(sync_v[i], 2) == filt_v[i] && $past(sync_v[i], 3) == filt_v[i]));
    end

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
    .W            (W),
    .FIXED_IN_BIT (FIXED_IN_BIT),
    .OD_ONLY_MASK (OD_ONLY_MASK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pd       (pad_pd_en),
    .pus      (pad_pu_strong_en),
    .puw      (pad_pu_weak_en),
    .cfg1_eff (cfg1_eff),
    .cfg2_eff (cfg2_eff),
    .latch_q  (latch_q),
    .sync_v   (sync_vec),
    .filt_v   (filt_vec)
);

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic [W-1:0] pad_in = '1;
    logic [W-1:0] pad_pd_en, pad_pu_strong_en, pad_pu_weak_en, pin_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_port_ctrl dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .reg_wr           (reg_wr),
        .reg_addr         (reg_addr),
        .reg_wdata        (reg_wdata),
        .reg_rdata        (reg_rdata),
        .pad_in           (pad_in),
        .pad_pd_en        (pad_pd_en),
        .pad_pu_strong_en (pad_pu_strong_en),
        .pad_pu_weak_en   (pad_pu_weak_en),
        .pin_level        (pin_level)
    );

    // {cfg1, cfg2, latch}
    localparam logic [23:0] VEC [0:5] = '{
        {8'h00, 8'h00, 8'hFF},
        {8'h00, 8'h00, 8'h00},
        {8'h00, 8'hFF, 8'hA5},
        {8'hFF, 8'hFF, 8'h3C},
        {8'hFF, 8'h00, 8'h00},
        {8'h0F, 8'h33, 8'h96}
    };

    function automatic logic [1:0] eff_mode(int b, logic [1:0] raw);
        if (b == 5) return 2'b10;
        if (b == 2 || b == 3) return (raw == 2'b10) ? 2'b10 : 2'b11;
        return raw;
    endfunction

    // returns {cfg1_eff, cfg2_eff, pd, pu_strong, pu_weak} with boost over
    function automatic logic [39:0] model(logic [7:0] c1, logic [7:0] c2, logic [7:0] l);
        logic [7:0] e1, e2, pd, ps, pw;
        for (int b = 0; b < W; b++) begin
            logic [1:0] m;
            m = eff_mode(b, {c1[b], c2[b]});
            e1[b] = m[1];
            e2[b] = m[0];
            pd[b] = 1'b0; ps[b] = 1'b0; pw[b] = 1'b0;
            case (m)
                2'b00: begin pd[b] = !l[b]; pw[b] = l[b]; end
                2'b01: begin pd[b] = !l[b]; ps[b] = l[b]; end
                2'b11: pd[b] = !l[b];
                default: ;
            endcase
        end
        return {e1, e2, pd, ps, pw};
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [W-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        logic [39:0]  e;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd1, v); check("R1 cfg1", v, 8'hFF);
        rd(2'd2, v); check("R1 cfg2", v, 8'h00);
        rd(2'd3, v); check("R1 latch", v, 8'hFF);
        check("R1 drivers", pad_pd_en | pad_pu_strong_en | pad_pu_weak_en, 8'h00);
        rd(2'd0, v); check("R1 pins", v, 8'hFF);

        // R2 latch readback address ignores writes
        wr(2'd3, 8'h00);
        rd(2'd3, v); check("R2 addr3 write ignored", v, 8'hFF);

        // table: R2 R3 R4 R5 R6 R8 R9
        for (int i = 0; i < 6; i++) begin
            wr(2'd1, VEC[i][23:16]);
            wr(2'd2, VEC[i][15:8]);
            wr(2'd0, VEC[i][7:0]);
            edges(4);
            e = model(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
            rd(2'd1, v); check("R2/R8/R9 cfg1 readback", v, e[39:32]);
            rd(2'd2, v); check("R2/R8/R9 cfg2 readback", v, e[31:24]);
            rd(2'd3, v); check("R2 latch readback", v, VEC[i][7:0]);
            check("R3/R4/R5/R6 pull-down", pad_pd_en, e[23:16]);
            check("R3/R4/R9 strong pull-up", pad_pu_strong_en, e[15:8]);
            check("R3/R6/R8 weak pull-up", pad_pu_weak_en, e[7:0]);
        end

        // R9 direct: request quasi everywhere
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        rd(2'd1, v); check("R9 narrowed cfg1", v, 8'h2C);
        rd(2'd2, v); check("R9 narrowed cfg2", v, 8'h0C);

        // R7 boost: quasi bit 0, open-drain bit 2 both rise
        wr(2'd0, 8'h00);
        edges(3);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h05;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R7 boost cycle 1", pad_pu_strong_en, 8'h01);
        @(negedge clk);
        check("R7 boost cycle 2", pad_pu_strong_en, 8'h01);
        @(negedge clk);
        check("R7 boost ended", pad_pu_strong_en, 8'h00);
        check("R12 weak pull-up only on quasi", pad_pu_weak_en, 8'h01);

        // R10 / R11: level change, quasi bits filtered, bits 2,3,5 not
        @(negedge clk);
        pad_in = 8'h00;
        edges(1);
        rd(2'd0, v); check("R11 not yet synced", v, 8'hFF);
        edges(1);
        rd(2'd0, v); check("R11 unfiltered after 2 edges", v, 8'hD3);
        edges(2);
        rd(2'd0, v); check("R10 filtered held at 4 edges", v, 8'hD3);
        edges(1);
        rd(2'd0, v); check("R10 filtered after 5 edges", v, 8'h00);
        check("R10 pin_level port", pin_level, 8'h00);

        // R10 two-clock glitch rejected
        edges(2);
        pad_in = 8'hFF;
        edges(2);
        pad_in = 8'h00;
        rd(2'd0, v); check("R11 glitch seen unfiltered", v, 8'h2C);
        edges(6);
        rd(2'd0, v); check("R10 glitch rejected", v, 8'h00);

        // R10 three-clock pulse accepted
        pad_in = 8'hFF;
        edges(3);
        pad_in = 8'h00;
        edges(2);
        rd(2'd0, v); check("R10 3-clock pulse accepted", v, 8'hD3);
        edges(8);
        rd(2'd0, v); check("R10 returns low", v, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule